// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block orders the contact signals of one smart card slot. A host control bit asks for a session. When the card is seated, the supply supervisor is quiet and no fault is present, the block steps through a fixed ramp. It raises the slot's converter request first, then the card supply enable, then the data line enable, and last the card clock enable. Reset is held low while these steps run. Each step lands on a whole number of half time units after the request. One time unit T is two half-steps of `HALF_T_CYC` clocks; the default is 32, so T is 64 clocks.

A session ends when the host clears its bit. It also ends at once on a fault, on card removal or when the supervisor becomes active. In every case the block drops reset on the next edge and then releases clock, data line and supply in that order. Last, it withdraws its converter request and clamps all contacts low. On an emergency it sends a one-cycle pulse so that the host's start bit can be cleared. The converter is shared with a second slot: its enable is the OR of this slot's request and the other slot's powered flag. It therefore stays on while the other slot needs it.

Top module: `card_contact_seq`

## Requirements
- R1: After reset, and whenever no session is in progress, `clamp_o` is 1. All of `pwr_req_o`, `vcc_en_o`, `io_en_o`, `clk_en_o`, `rst_o`, `active_o` and `start_clr_o` are 0.
- R2: A request is accepted only when `start_i`=1, `present_i`=1, `sup_active_i`=0 and `fault_i`=0 are all sampled together in the idle state. Otherwise the block stays idle.
- R3: If a request is accepted at edge E, then `pwr_req_o` rises at E and `vcc_en_o` rises at E+3·HALF_T_CYC. `io_en_o` rises at E+7·HALF_T_CYC, and `clk_en_o` and `active_o` rise at E+8·HALF_T_CYC.
- R4: `dcdc_en_o` equals `pwr_req_o` OR `other_active_i`. While the other slot is powered, the converter stays enabled through this slot's whole activation and deactivation.
- R5: From a full session, a cleared `start_i` sampled at edge D forces `rst_o` to 0 at D. `clk_en_o` drops at D+HALF_T_CYC, `io_en_o` at D+2·HALF_T_CYC and `vcc_en_o` at D+3·HALF_T_CYC. `pwr_req_o` drops and `clamp_o` rises at D+7·HALF_T_CYC.
- R6: `fault_i`=1, `present_i`=0 or `sup_active_i`=1 during a session starts the same sequence as R5. It also gives `start_clr_o`=1 for exactly the one cycle after D.
- R7: After an emergency shutdown, no new session starts until `start_i` has been sampled low at least once.
- R8: A stop during activation starts the R5 sequence from that step. An enable that had not yet risen stays 0, and an enable already high drops at its R5 offset.
- R9: `active_o` is 1 from the end of activation until `clamp_o` rises. It stays 0 throughout an activation that is aborted.
- R10: `rst_o` follows `card_rst_i` only while the session is fully active. It is 0 in every other state.
- R11: During deactivation a new `start_i`=1 has no effect until `clamp_o` rises. From the next edge after that, a request that meets R2 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Host session request bit |
| present_i | input | 1 | Card presence, 1 = seated |
| sup_active_i | input | 1 | Supply supervisor active |
| fault_i | input | 1 | Overcurrent on supply or reset contact |
| other_active_i | input | 1 | Other slot has the converter in use |
| card_rst_i | input | 1 | Reset level requested by answer-to-reset timing logic |
| pwr_req_o | output | 1 | This slot's converter request, for the other slot |
| dcdc_en_o | output | 1 | Shared converter enable |
| vcc_en_o | output | 1 | Card supply enable |
| io_en_o | output | 1 | Card data line enable |
| clk_en_o | output | 1 | Card clock enable |
| rst_o | output | 1 | Card reset contact level |
| clamp_o | output | 1 | All contacts held low to card ground |
| active_o | output | 1 | Session fully active |
| start_clr_o | output | 1 | One-cycle request to clear the host start bit |

## Verification
A wrong step count or a wrong state shows up as an enable edge on the wrong cycle. An edge can come early or late, or an enable can be missing during an aborted ramp. The reference model predicts every output on every clock, so such an error is reported on the first cycle where the order differs. A lost emergency latch shows up later: a session restarts while the start bit is still high after a fault. The bench catches it within a few cycles of the clamp. A wrong snapshot of enables taken at abort shows up as a contact that turns on during shutdown.

// File: rtl/cardseq_pkg.sv
package cardseq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_UP   = 2'd1,
    SEQ_ON   = 2'd2,
    SEQ_DOWN = 2'd3
  } seq_state_e;

  localparam int unsigned N_LANES = 4;
  localparam int unsigned LN_PWR  = 0;
  localparam int unsigned LN_VCC  = 1;
  localparam int unsigned LN_IO   = 2;
  localparam int unsigned LN_CLK  = 3;

  // ramp and release spans in half time units
  localparam int unsigned UP_SPAN_HALF = 8;
  localparam int unsigned DN_SPAN_HALF = 7;

  function automatic int unsigned up_half(int unsigned lane);
    case (lane)
      LN_PWR:  return 0;
      LN_VCC:  return 3;
      LN_IO:   return 7;
      default: return 8;
    endcase
  endfunction

  function automatic int unsigned dn_half(int unsigned lane);
    case (lane)
      LN_PWR:  return 7;
      LN_VCC:  return 3;
      LN_IO:   return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/cardseq_step_cnt.sv
module cardseq_step_cnt #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/cardseq_ctrl.sv
module cardseq_ctrl
  import cardseq_pkg::*;
#(
  parameter int unsigned HALF_T_CYC = 32,
  parameter int unsigned CNT_W      = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 present_i,
  input  logic                 sup_active_i,
  input  logic                 fault_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [N_LANES-1:0]   lanes_i,
  output seq_state_e           state_o,
  output logic                 cnt_clr_o,
  output logic [N_LANES-1:0]   snap_o,
  output logic                 snap_active_o,
  output logic                 start_clr_o
);

  localparam logic [CNT_W-1:0] UP_LAST = CNT_W'(UP_SPAN_HALF * HALF_T_CYC - 1);
  localparam logic [CNT_W-1:0] DN_LAST = CNT_W'(DN_SPAN_HALF * HALF_T_CYC - 1);

  seq_state_e state_q, state_d;
  logic       need_low_q;
  logic       emerg, stop, accept, enter_down;

  assign emerg  = fault_i | ~present_i | sup_active_i;
  assign stop   = ~start_i | emerg;
  assign accept = start_i & ~need_low_q & present_i & ~sup_active_i & ~fault_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (accept) state_d = SEQ_UP;
      SEQ_UP: begin
        if (stop)                  state_d = SEQ_DOWN;
        else if (cnt_i == UP_LAST) state_d = SEQ_ON;
      end
      SEQ_ON:   if (stop) state_d = SEQ_DOWN;
      SEQ_DOWN: if (cnt_i == DN_LAST) state_d = SEQ_IDLE;
    endcase
  end

  assign enter_down = (state_d == SEQ_DOWN) && (state_q != SEQ_DOWN);
  assign cnt_clr_o  = (state_d != state_q) || (state_q == SEQ_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= SEQ_IDLE;
      need_low_q    <= 1'b0;
      snap_o        <= '0;
      snap_active_o <= 1'b0;
      start_clr_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      start_clr_o <= enter_down & emerg;
      if (enter_down) begin
        snap_o        <= lanes_i;
        snap_active_o <= (state_q == SEQ_ON);
      end
      // after an emergency the host bit must be seen low before a new session
      if (enter_down && emerg) need_low_q <= 1'b1;
      else if (!start_i)       need_low_q <= 1'b0;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/cardseq_lanes.sv
module cardseq_lanes
  import cardseq_pkg::*;
#(
  parameter int unsigned HALF_T_CYC = 32,
  parameter int unsigned CNT_W      = 9
) (
  input  seq_state_e         state_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [N_LANES-1:0] snap_i,
  output logic [N_LANES-1:0] lanes_o
);

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    localparam logic [CNT_W-1:0] ON_AT  = CNT_W'(up_half(k) * HALF_T_CYC);
    localparam logic [CNT_W-1:0] OFF_AT = CNT_W'(dn_half(k) * HALF_T_CYC);
    always_comb begin
      unique case (state_i)
        SEQ_IDLE: lanes_o[k] = 1'b0;
        SEQ_UP:   lanes_o[k] = (cnt_i >= ON_AT);
        SEQ_ON:   lanes_o[k] = 1'b1;
        SEQ_DOWN: lanes_o[k] = snap_i[k] && (cnt_i < OFF_AT);
      endcase
    end
  end

endmodule

// File: rtl/card_contact_seq.sv
module card_contact_seq
  import cardseq_pkg::*;
#(
  parameter int unsigned HALF_T_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic present_i,
  input  logic sup_active_i,
  input  logic fault_i,
  input  logic other_active_i,
  input  logic card_rst_i,
  output logic pwr_req_o,
  output logic dcdc_en_o,
  output logic vcc_en_o,
  output logic io_en_o,
  output logic clk_en_o,
  output logic rst_o,
  output logic clamp_o,
  output logic active_o,
  output logic start_clr_o
);

  localparam int unsigned CNT_W = $clog2(UP_SPAN_HALF * HALF_T_CYC + 1);

  seq_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic               cnt_clr;
  logic [N_LANES-1:0] lanes, snap;
  logic               snap_active;

  cardseq_step_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt)
  );

  cardseq_ctrl #(.HALF_T_CYC(HALF_T_CYC), .CNT_W(CNT_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .present_i     (present_i),
    .sup_active_i  (sup_active_i),
    .fault_i       (fault_i),
    .cnt_i         (cnt),
    .lanes_i       (lanes),
    .state_o       (state),
    .cnt_clr_o     (cnt_clr),
    .snap_o        (snap),
    .snap_active_o (snap_active),
    .start_clr_o   (start_clr_o)
  );

  cardseq_lanes #(.HALF_T_CYC(HALF_T_CYC), .CNT_W(CNT_W)) u_lanes (
    .state_i (state),
    .cnt_i   (cnt),
    .snap_i  (snap),
    .lanes_o (lanes)
  );

  assign pwr_req_o = lanes[LN_PWR];
  assign dcdc_en_o = lanes[LN_PWR] | other_active_i;
  assign vcc_en_o  = lanes[LN_VCC];
  assign io_en_o   = lanes[LN_IO];
  assign clk_en_o  = lanes[LN_CLK];
  assign rst_o     = (state == SEQ_ON) & card_rst_i;
  assign clamp_o   = (state == SEQ_IDLE);
  assign active_o  = (state == SEQ_ON) | ((state == SEQ_DOWN) & snap_active);

endmodule

// File: rtl/card_contact_seq_chk.sv
module card_contact_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic present_i,
  input logic sup_active_i,
  input logic fault_i,
  input logic other_active_i,
  input logic pwr_req_o,
  input logic dcdc_en_o,
  input logic vcc_en_o,
  input logic io_en_o,
  input logic clk_en_o,
  input logic rst_o,
  input logic clamp_o,
  input logic active_o,
  input logic start_clr_o
);

  AST_CLAMP_ALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o |-> !(pwr_req_o || vcc_en_o || io_en_o || clk_en_o || rst_o || active_o)); // R1

  AST_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_o && (!start_i || !present_i || sup_active_i || fault_i)) |=> clamp_o); // R2

  AST_VCC_AFTER_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_en_o |-> pwr_req_o); // R3

  AST_IO_AFTER_VCC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_en_o |-> vcc_en_o); // R3

  AST_CLK_AFTER_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> io_en_o); // R5

  AST_SHARED_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (other_active_i || pwr_req_o) |-> dcdc_en_o); // R4

  AST_FAULT_RST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && !clamp_o) |=> !rst_o); // R6

  AST_CLR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_clr_o |=> !start_clr_o); // R6

  AST_CLK_RISE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> active_o); // R9

  AST_RST_ONLY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> (active_o && clk_en_o)); // R10

endmodule

bind card_contact_seq card_contact_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .present_i      (present_i),
  .sup_active_i   (sup_active_i),
  .fault_i        (fault_i),
  .other_active_i (other_active_i),
  .pwr_req_o      (pwr_req_o),
  .dcdc_en_o      (dcdc_en_o),
  .vcc_en_o       (vcc_en_o),
  .io_en_o        (io_en_o),
  .clk_en_o       (clk_en_o),
  .rst_o          (rst_o),
  .clamp_o        (clamp_o),
  .active_o       (active_o),
  .start_clr_o    (start_clr_o)
);

// File: tb/card_contact_seq_tb.sv
`timescale 1ns/1ps
module card_contact_seq_tb;

  localparam int H = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, present_i = 0, sup_active_i = 0, fault_i = 0;
  logic other_active_i = 0, card_rst_i = 0;
  logic pwr_req_o, dcdc_en_o, vcc_en_o, io_en_o, clk_en_o, rst_o;
  logic clamp_o, active_o, start_clr_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk_i = ~clk_i;

  card_contact_seq #(.HALF_T_CYC(H)) u_dut (.*);

  // behavioural reference: timestamps in cycles since last state entry
  int m_st = 0;
  int m_el = 0;
  bit m_snap [4];
  bit m_sact = 0, m_nl = 0, m_clr = 0;
  int up_at [4] = '{0, 3, 7, 8};
  int dn_at [4] = '{7, 3, 2, 1};

  function automatic bit exp_lane(int k);
    case (m_st)
      1: return m_el >= up_at[k] * H;
      2: return 1'b1;
      3: return m_snap[k] && (m_el < dn_at[k] * H);
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_el = 0; m_sact = 0; m_nl = 0; m_clr = 0;
      foreach (m_snap[i]) m_snap[i] = 0;
    end else begin
      bit emerg, stop, go_down, nl_set;
      emerg = fault_i || !present_i || sup_active_i;
      stop = !start_i || emerg;
      go_down = 0;
      case (m_st)
        0: if (start_i && !m_nl && present_i && !sup_active_i && !fault_i) begin
             m_st = 1; m_el = 0;
           end
        1: if (stop) go_down = 1;
           else begin
             m_el++;
             if (m_el == 8 * H) begin m_st = 2; m_el = 0; end
           end
        2: if (stop) go_down = 1;
        default: begin
          m_el++;
          if (m_el == 7 * H) begin m_st = 0; m_el = 0; end
        end
      endcase
      nl_set = go_down && emerg;
      m_clr = nl_set;
      if (go_down) begin
        for (int k = 0; k < 4; k++) m_snap[k] = exp_lane(k);
        m_sact = (m_st == 2);
        m_st = 3; m_el = 0;
      end
      if (nl_set) m_nl = 1;
      else if (!start_i) m_nl = 0;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic [8:0] act, expv;
      #1;
      act = {pwr_req_o, dcdc_en_o, vcc_en_o, io_en_o, clk_en_o, rst_o,
             clamp_o, active_o, start_clr_o};
      expv = {exp_lane(0), exp_lane(0) | other_active_i, exp_lane(1), exp_lane(2),
              exp_lane(3), (m_st == 2) && card_rst_i, m_st == 0,
              (m_st == 2) || (m_st == 3 && m_sact), m_clr};
      checks++;
      if (act !== expv) begin
        failures++;
        $display("FAIL %s cycle %0d outputs actual=%b expected=%b", cur_req, cyc, act, expv);
      end
    end
  end

  task automatic point(input string req, input logic a, input logic e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s point check actual=%b expected=%b", req, a, e);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog run did not complete");
      finish_run();
    end
  end

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(2);
    #2;
    point("R1", clamp_o, 1'b1);
    point("R1", vcc_en_o | pwr_req_o | active_o, 1'b0);

    cur_req = "R2";
    @(negedge clk_i);
    start_i = 1;
    wait_n(20);
    present_i = 1; sup_active_i = 1;
    wait_n(20);
    sup_active_i = 0; fault_i = 1;
    wait_n(10);
    #2 point("R2", clamp_o, 1'b1);
    @(negedge clk_i);
    start_i = 0; fault_i = 0;
    wait_n(4);

    cur_req = "R3";
    start_i = 1;
    wait_n(8 * H + 4);
    cur_req = "R10";
    card_rst_i = 1;
    wait_n(10);
    #2 point("R10", rst_o, 1'b1);
    point("R9", active_o, 1'b1);
    @(negedge clk_i);
    cur_req = "R5";
    start_i = 0;
    wait_n(7 * H + 4);
    #2 point("R5", clamp_o, 1'b1);
    @(negedge clk_i);
    card_rst_i = 0;

    cur_req = "R4";
    other_active_i = 1;
    start_i = 1;
    wait_n(8 * H + 20);
    start_i = 0;
    wait_n(7 * H + 5);
    #2 point("R4", dcdc_en_o, 1'b1);
    @(negedge clk_i);
    other_active_i = 0;
    wait_n(3);

    cur_req = "R8";
    start_i = 1;
    wait_n(5 * H);
    start_i = 0;
    wait_n(7 * H + 5);
    #2 point("R8", clamp_o, 1'b1);
    @(negedge clk_i);

    cur_req = "R6";
    start_i = 1; card_rst_i = 1;
    wait_n(8 * H + 10);
    fault_i = 1;
    wait_n(2);
    fault_i = 0;
    cur_req = "R7";
    wait_n(7 * H + 30);
    #2 point("R7", clamp_o, 1'b1);
    @(negedge clk_i);
    start_i = 0;
    wait_n(2);
    start_i = 1;
    wait_n(8 * H + 10);
    #2 point("R7", active_o, 1'b1);
    @(negedge clk_i);
    cur_req = "R6";
    present_i = 0;
    wait_n(7 * H + 5);
    present_i = 1; start_i = 0;
    wait_n(2);
    start_i = 1;
    wait_n(8 * H + 10);
    sup_active_i = 1;
    wait_n(3);
    sup_active_i = 0;
    wait_n(7 * H + 5);
    start_i = 0;
    wait_n(3);

    cur_req = "R11";
    start_i = 1;
    wait_n(8 * H + 10);
    start_i = 0;
    wait_n(50);
    start_i = 1;
    wait_n(7 * H + 40);
    #2 point("R11", clamp_o, 1'b0);
    @(negedge clk_i);
    start_i = 0;
    wait_n(7 * H + 10);
    #2 point("R1", clamp_o, 1'b1);

    finish_run();
  end

endmodule